// File: doc/BRIEF.md
# Memory Request Packet Builder

This block turns a memory read or memory write command into a transaction-layer request packet, emitted as a stream of 32-bit dwords. A command carries the operation, a 64-bit target address, a length in dwords, a 16-bit requester identifier, an 8-bit tag and two 4-bit byte-enable masks. The block builds the header, sends it dword by dword on a valid/ready output stream, and for a write then forwards the payload stream behind the header, marking the final dword of every packet.

The header is three dwords when the upper half of the address is zero and four dwords otherwise. Only one packet is in flight at a time: the command port stays closed from the moment a command is taken until the final dword of its packet has been accepted downstream. Link-level sequence numbers, checksums, framing and credit accounting belong to other blocks.

Top module: `tlp_mem_req_builder`

## Requirements
- R1: After reset, `out_valid` and `pld_ready` are 0 and `cmd_ready` is 1.
- R2: A read whose address has bits [63:32] zero produces exactly three dwords. Dword 0 holds the format code in bits [31:29] (3'b000), the type code 5'b00000 in bits [28:24], zeros in bits [23:10] and the length field in bits [9:0]; `out_last` is 1 on the third dword only.
- R3: A write whose address has bits [63:32] zero uses format code 3'b010 (so dword 0 bits [31:24] are 0x40), sends three header dwords and then the payload dwords in arrival order; `out_last` is 1 on the final payload dword only.
- R4: When address bits [63:32] are nonzero the header has four dwords, the format code is 3'b001 for a read and 3'b011 for a write, dword 2 carries address bits [63:32] and dword 3 carries address bits [31:2] in positions [31:2].
- R5: Header dword 1 is {requester ID in [31:16], tag in [15:8], last byte enable in [7:4], first byte enable in [3:0]}.
- R6: Address bits [1:0] are never transmitted; the dword carrying the low address always has bits [1:0] equal to 0.
- R7: The length field counts dwords and is sent as given; the value 0 stands for 1024 dwords, so a write of length 0 forwards 1024 payload dwords.
- R8: For a request of length 1 the last byte enable field is sent as 4'b0000 whatever the command supplies; for other lengths both masks are sent as given.
- R9: `cmd_ready` goes to 0 in the cycle after a command is accepted and stays 0 until the cycle after the final dword of the packet is accepted, when it returns to 1.
- R10: While `out_valid` is 1 and `out_ready` is 0 during the header, `out_data` and `out_last` hold their values. `pld_ready` is 1 only during the payload phase of a write, and there it equals `out_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command port open |
| cmd_write | input | 1 | 1 = memory write, 0 = memory read |
| cmd_addr | input | 64 | Byte address of the first dword |
| cmd_len | input | 10 | Length in dwords, 0 means 1024 |
| cmd_req_id | input | 16 | Requester identifier |
| cmd_tag | input | 8 | Transaction tag |
| cmd_first_be | input | 4 | Byte enables of the first dword |
| cmd_last_be | input | 4 | Byte enables of the last dword |
| pld_valid | input | 1 | Payload dword offered |
| pld_ready | output | 1 | Payload dword taken |
| pld_data | input | 32 | Payload dword |
| out_valid | output | 1 | Output dword valid |
| out_ready | input | 1 | Downstream accepts the dword |
| out_data | output | 32 | Output dword |
| out_last | output | 1 | Final dword of the packet |

## Verification
The bench aims at the header-size boundary: an address whose upper half is zero except for one bit, and one with only bit 32 set, where a design testing the wrong bits would send a three-dword header with a truncated address. It sends the length code 0, which a design treating it as zero would close after the header or stall, and a single-dword request carrying a full last mask, which a design that does not clear it would send unchanged. Random output stalls and payload gaps go after a sequencer that skips or repeats dwords, misplaces the last marker, or reopens the command port before the final handshake; low address bits are set to catch a design that leaks them into the header.

// File: rtl/tlp_req_pkg.sv
package tlp_req_pkg;

  localparam int DW_W    = 32;
  localparam int ADDR_W  = 64;
  localparam int LEN_W   = 10;
  localparam int RID_W   = 16;
  localparam int TAG_W   = 8;
  localparam int BE_W    = 4;
  localparam int HDR_MAX = 4;
  localparam int IDX_W   = $clog2(HDR_MAX);
  localparam int CNT_W   = LEN_W + 1;

  // format codes: bit 1 = carries data, bit 0 = four-dword header
  localparam logic [2:0] FMT_RD3 = 3'b000;
  localparam logic [2:0] FMT_RD4 = 3'b001;
  localparam logic [2:0] FMT_WR3 = 3'b010;
  localparam logic [2:0] FMT_WR4 = 3'b011;
  localparam logic [4:0] TYPE_MEM = 5'b00000;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HDR  = 2'd1,
    SEQ_PAY  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic [RID_W-1:0]  rid;
    logic [TAG_W-1:0]  tag;
    logic [BE_W-1:0]   fbe;
    logic [BE_W-1:0]   lbe;
  } req_cmd_t;

endpackage

// File: rtl/tlp_hdr_pack.sv
module tlp_hdr_pack
  import tlp_req_pkg::*;
(
  input  req_cmd_t                      cmd,
  output logic [HDR_MAX-1:0][DW_W-1:0]  hdr_dw,
  output logic                          four_dw
);

  localparam int HALF_W = ADDR_W / 2;

  logic [2:0]      fmt;
  logic [BE_W-1:0] lbe_eff;
  logic [DW_W-1:0] addr_lo_dw;

  always_comb begin
    four_dw = |cmd.addr[ADDR_W-1:HALF_W];
    unique case ({cmd.wr, four_dw})
      2'b00:   fmt = FMT_RD3;
      2'b01:   fmt = FMT_RD4;
      2'b10:   fmt = FMT_WR3;
      default: fmt = FMT_WR4;
    endcase
    lbe_eff    = (cmd.len == LEN_W'(1)) ? '0 : cmd.lbe;
    addr_lo_dw = {cmd.addr[HALF_W-1:2], 2'b00};
  end

  always_comb begin
    hdr_dw[0] = {fmt, TYPE_MEM, {(DW_W-8-LEN_W){1'b0}}, cmd.len};
    hdr_dw[1] = {cmd.rid, cmd.tag, lbe_eff, cmd.fbe};
    if (four_dw) begin
      hdr_dw[2] = cmd.addr[ADDR_W-1:HALF_W];
      hdr_dw[3] = addr_lo_dw;
    end else begin
      hdr_dw[2] = addr_lo_dw;
      hdr_dw[3] = '0;
    end
  end

endmodule

// File: rtl/tlp_dw_counter.sv
module tlp_dw_counter #(
  parameter int LEN_BITS = 10,
  localparam int CW      = LEN_BITS + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [LEN_BITS-1:0] load_len,
  input  logic                dec,
  output logic                at_one
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      // a zero length code stands for the largest count
      cnt_d = (load_len == '0) ? CW'(1) << LEN_BITS : {1'b0, load_len};
    end else if (dec && cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign at_one = (cnt_q == CW'(1));

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (CW'(1) << LEN_BITS));

endmodule

// File: rtl/tlp_mem_req_builder.sv
module tlp_mem_req_builder
  import tlp_req_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [RID_W-1:0]  cmd_req_id,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic [BE_W-1:0]   cmd_first_be,
  input  logic [BE_W-1:0]   cmd_last_be,
  input  logic              pld_valid,
  output logic              pld_ready,
  input  logic [DW_W-1:0]   pld_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW_W-1:0]   out_data,
  output logic              out_last
);

  seq_state_e state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  req_cmd_t cmd_q, cmd_in;
  logic [HDR_MAX-1:0][DW_W-1:0] hdr_dw;
  logic four_dw;
  logic [IDX_W-1:0] last_idx;
  logic cmd_fire, out_fire, hdr_end, pay_last;

  assign cmd_in = '{wr: cmd_write, addr: cmd_addr, len: cmd_len,
                    rid: cmd_req_id, tag: cmd_tag,
                    fbe: cmd_first_be, lbe: cmd_last_be};

  assign cmd_ready = (state_q == SEQ_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign out_fire  = out_valid && out_ready;

  // command register, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (cmd_fire) cmd_q <= cmd_in;
  end

  tlp_hdr_pack u_pack (
    .cmd     (cmd_q),
    .hdr_dw  (hdr_dw),
    .four_dw (four_dw)
  );

  tlp_dw_counter #(.LEN_BITS(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd_fire),
    .load_len (cmd_len),
    .dec      (out_fire && state_q == SEQ_PAY),
    .at_one   (pay_last)
  );

  assign last_idx = four_dw ? IDX_W'(HDR_MAX-1) : IDX_W'(HDR_MAX-2);
  assign hdr_end  = (idx_q == last_idx);

  // next state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      SEQ_IDLE: if (cmd_fire) begin
        state_d = SEQ_HDR;
        idx_d   = '0;
      end
      SEQ_HDR: if (out_fire) begin
        if (hdr_end) begin
          state_d = cmd_q.wr ? SEQ_PAY : SEQ_IDLE;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      SEQ_PAY: if (out_fire && pay_last) state_d = SEQ_IDLE;
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // output mux
  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    pld_ready = 1'b0;
    unique case (state_q)
      SEQ_HDR: begin
        out_valid = 1'b1;
        out_data  = hdr_dw[idx_q];
        out_last  = hdr_end && !cmd_q.wr;
      end
      SEQ_PAY: begin
        out_valid = pld_valid;
        out_data  = pld_data;
        out_last  = pay_last;
        pld_ready = out_ready;
      end
      default: ;
    endcase
  end

  // R9
  cmd_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  // R9
  cmd_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> cmd_ready);

  // R10
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SEQ_HDR && !out_ready |=>
      out_valid && $stable(out_data) && $stable(out_last));

  // R10
  pld_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pld_ready |-> out_ready && cmd_q.wr && !cmd_ready);

  // R8
  single_lbe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SEQ_HDR && idx_q == IDX_W'(1) && cmd_q.len == LEN_W'(1)
      |-> out_data[7:4] == 4'b0000);

  // R6
  addr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SEQ_HDR && hdr_end |-> out_data[1:0] == 2'b00);

endmodule

// File: tb/tb_tlp_mem_req_builder.sv
module tb_tlp_mem_req_builder;

  typedef struct {
    logic [31:0] data;
    logic        last;
    logic        pay;
    int          req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_ready, cmd_write;
  logic [63:0] cmd_addr;
  logic [9:0] cmd_len;
  logic [15:0] cmd_req_id;
  logic [7:0] cmd_tag;
  logic [3:0] cmd_first_be, cmd_last_be;
  logic pld_valid, pld_ready;
  logic [31:0] pld_data;
  logic out_valid, out_ready, out_last;
  logic [31:0] out_data;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  int stall_mode = 1;
  logic pkt_busy_err = 1'b0;
  logic pkt_pld_err = 1'b0;
  logic reopen_pending = 1'b0;

  always #10 clk = ~clk;

  tlp_mem_req_builder dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_req_id(cmd_req_id),
    .cmd_tag(cmd_tag), .cmd_first_be(cmd_first_be), .cmd_last_be(cmd_last_be),
    .pld_valid(pld_valid), .pld_ready(pld_ready), .pld_data(pld_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // downstream ready pattern
  initial begin
    out_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (stall_mode != 0) out_ready = (($urandom % 4) != 0);
      else out_ready = 1'b1;
    end
  end

  // monitor: compare every accepted output dword with the scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (reopen_pending) begin
          // R9: reopened the cycle after the final handshake
          check(cmd_ready === 1'b1, "R9 reopen", 64'(cmd_ready), 64'd1);
          reopen_pending = 1'b0;
        end
        if (out_valid && cmd_ready) pkt_busy_err = 1'b1;
        if (pld_ready && (exp_q.size() == 0 || !exp_q[0].pay)) pkt_pld_err = 1'b1;
        if (pld_ready !== out_ready && pld_ready) pkt_pld_err = 1'b1;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected dword", 64'(out_data), 64'd0);
          end else begin
            e = exp_q.pop_front();
            check(out_data === e.data && out_last === e.last,
                  $sformatf("R%0d data/last", e.req),
                  {31'd0, out_last, out_data}, {31'd0, e.last, e.data});
            if (e.last) begin
              // R9: port closed for the whole packet
              check(!pkt_busy_err, "R9 busy", 64'(pkt_busy_err), 64'd0);
              // R10: payload taken only in write payload phase
              check(!pkt_pld_err, "R10 pld_ready", 64'(pkt_pld_err), 64'd0);
              pkt_busy_err = 1'b0;
              pkt_pld_err = 1'b0;
              reopen_pending = 1'b1;
            end
          end
        end
      end
    end
  end

  // driver: builds the expected packet from the requirements, then drives
  task automatic send(input bit wr, input logic [63:0] addr, input logic [9:0] len,
                      input logic [15:0] rid, input logic [7:0] tag,
                      input logic [3:0] fbe, input logic [3:0] lbe, input int req);
    bit big = (addr[63:32] != 32'd0);
    int nd = (len == 10'd0) ? 1024 : int'(len);
    logic [2:0] f = {1'b0, wr, big};
    logic [3:0] lb = (len == 10'd1) ? 4'b0000 : lbe;   // R8
    logic [31:0] lo = {addr[31:2], 2'b00};              // R6
    exp_q.push_back('{{f, 5'b00000, 14'd0, len}, 1'b0, 1'b0, req});      // R2
    exp_q.push_back('{{rid, tag, lb, fbe}, 1'b0, 1'b0, req});            // R5
    if (big) begin                                                       // R4
      exp_q.push_back('{addr[63:32], 1'b0, 1'b0, req});
      exp_q.push_back('{lo, !wr, 1'b0, req});
    end else begin
      exp_q.push_back('{lo, !wr, 1'b0, req});
    end
    cmd_write = wr; cmd_addr = addr; cmd_len = len; cmd_req_id = rid;
    cmd_tag = tag; cmd_first_be = fbe; cmd_last_be = lbe; cmd_valid = 1'b1;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    cmd_addr = '1;   // scramble to prove the command was captured
    if (wr) begin
      for (int i = 0; i < nd; i++) begin
        logic [31:0] d = 32'hD000_0000 ^ (32'(i) * 32'h0101_0013) ^ {16'd0, rid};
        exp_q.push_back('{d, i == nd - 1, 1'b1, req});                   // R3 R7
        if (($urandom % 5) == 0) begin
          pld_valid = 1'b0;
          @(posedge clk); #1;
        end
        pld_valid = 1'b1;
        pld_data = d;
        do @(negedge clk); while (!pld_ready);
        @(posedge clk); #1;
        pld_valid = 1'b0;
      end
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || reopen_pending) @(posedge clk);
    @(posedge clk); #1;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0;
    cmd_len = '0; cmd_req_id = '0; cmd_tag = '0; cmd_first_be = '0;
    cmd_last_be = '0; pld_valid = 1'b0; pld_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(out_valid === 1'b0 && pld_ready === 1'b0 && cmd_ready === 1'b1,
          "R1 reset", {61'd0, out_valid, pld_ready, cmd_ready}, 64'd1);
    @(posedge clk); #1;

    // R2: 32-bit read of 32 dwords, full masks
    send(1'b0, 64'h0000_0000_001A_D000, 10'h020, 16'h3F00, 8'h80, 4'hF, 4'hF, 2);
    drain();
    // R3: 32-bit write of three dwords
    send(1'b1, 64'h0000_0000_001A_D000, 10'd3, 16'h3F00, 8'h00, 4'hF, 4'hF, 3);
    drain();
    // R4: 64-bit read, only bit 32 set in the upper half
    send(1'b0, 64'h0000_0001_0000_0040, 10'd8, 16'h1234, 8'h5A, 4'hE, 4'h3, 4);
    drain();
    // R4: 64-bit write, top bit set
    send(1'b1, 64'h8000_0000_FFFF_FFF0, 10'd5, 16'hBEEF, 8'hC3, 4'h1, 4'h8, 4);
    drain();
    // R6: low address bits set, 32-bit boundary address
    send(1'b0, 64'h0000_0000_FFFF_FFFF, 10'd2, 16'h0001, 8'hFF, 4'h8, 4'h1, 6);
    drain();
    // R8: single dword with a nonzero last mask supplied
    send(1'b1, 64'h0000_0000_0000_1004, 10'd1, 16'hA5A5, 8'h11, 4'h6, 4'hF, 8);
    drain();
    send(1'b0, 64'h0000_0002_0000_2000, 10'd1, 16'h5A5A, 8'h22, 4'hF, 4'hC, 8);
    drain();
    // R5: varied identifier / tag / masks, back to back without draining
    send(1'b0, 64'h0000_0000_0000_3000, 10'h3FF, 16'hFFFF, 8'h01, 4'h3, 4'hC, 5);
    send(1'b1, 64'h0000_0000_0000_4000, 10'd2, 16'h0000, 8'hFE, 4'hC, 4'h3, 5);
    send(1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 10'd4, 16'h8001, 8'h7F, 4'hF, 4'hF, 5);
    drain();
    // R10: long write with continuous stalls
    send(1'b1, 64'h0000_0000_0010_0000, 10'd16, 16'h0F0F, 8'h33, 4'hF, 4'hF, 10);
    drain();
    // R7: length code 0 means 1024 payload dwords
    stall_mode = 0;
    send(1'b1, 64'h0000_0000_0020_0000, 10'd0, 16'h7777, 8'h44, 4'hF, 4'hF, 7);
    drain();
    stall_mode = 1;
    send(1'b0, 64'h0000_0000_0030_0000, 10'd0, 16'h7778, 8'h45, 4'hF, 4'hF, 7);
    drain();

    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule